// File: doc/BRIEF.md
# Reciprocal Estimator

This unit returns a coarse approximation of 1/x, good to about eight bits. A request carries a 32-bit operand and a mode bit. In floating-point mode the operand is a single-precision number. The unit classifies it and handles the special values. For ordinary operands it builds the result exponent from the input exponent, copies the sign, and takes the result mantissa from a 256-entry constant table. The table is indexed by the eight leading fraction bits. In unsigned mode the operand is a 32-bit fixed-point fraction with the binary point above bit 31. Operands in [0.5, 1) are looked up in the same table, and the estimate comes back as a fixed-point fraction with the binary point below bit 31.

A small state machine sequences each request through four named states. IDLE waits for work. DECODE registers the operand class, sign, result exponent and table index. LOOKUP reads the table and registers the assembled result and flags. EMIT presents the result for one cycle. The transitions are as follows:
- IDLE goes to DECODE on an accepted request and otherwise stays in IDLE.
- DECODE always goes to LOOKUP.
- LOOKUP always goes to EMIT.
- EMIT goes to DECODE when a new request is offered in that cycle, and otherwise returns to IDLE.

The table entry for index i is computed as follows:
1. Set q = 256 + i.
2. Set r = 512 / (q + 0.5).
3. Set s = floor(256·r + 0.5).
4. Store s − 256 as an 8-bit value.

Top module: `recip_estimator`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, out_valid is 0, in_ready is 1, and out_result together with the three flags reads zero.
- R2: A request is taken at a rising edge where in_valid and in_ready are both 1. Its result is presented with out_valid = 1 for exactly one cycle, after the third rising edge counted from acceptance. in_ready is 0 in the two cycles between. in_ready is 1 in the EMIT cycle, so a request offered then is accepted back-to-back.
- R3: In float mode (in_mode = 0), an operand with exponent field 255 and a nonzero fraction returns 0x7FC00000. out_invalid is set exactly when fraction bit 22 is 0.
- R4: A float operand with exponent field 255 and a zero fraction returns zero carrying the operand's sign bit, with no flag set.
- R5: A float operand with exponent field 0 returns infinity carrying the operand's sign, {sign, 0xFF, 23'b0}, and sets out_divzero. This covers zero and subnormal operands alike.
- R6: A float operand with exponent field 253 or 254 returns zero carrying the operand's sign and sets out_underflow.
- R7: A float operand with exponent field E in 1..252 returns the sign bit copied from the operand, exponent 253 − E, and mantissa T[i] << 15. Here i is operand bits 22:15 and T is the table above. No flag is set.
- R8: In unsigned mode (in_mode = 1), an operand with bit 31 clear returns 0xFFFFFFFF.
- R9: In unsigned mode, an operand with bit 31 set returns bit 31 = 1, bits 30:23 = T[i] with i = operand bits 30:23, and bits 22:0 = 0.
- R10: Unsigned mode never raises a flag. In any mode at most one of the three flags is 1 with a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The unit can take a request this cycle |
| in_mode | input | 1 | 0: single-precision operand, 1: unsigned fixed-point operand |
| in_operand | input | 32 | Operand bits |
| out_valid | output | 1 | Result and flags are valid this cycle |
| out_result | output | 32 | Estimate bits |
| out_invalid | output | 1 | Signalling NaN operand |
| out_divzero | output | 1 | Zero or subnormal operand |
| out_underflow | output | 1 | Operand magnitude at or above 2^126 |

## Verification
Two events can share the EMIT cycle: one request's result leaving the unit and the next request being accepted. The bench provokes this by offering a second operand exactly in the cycle where it sees out_valid. In that cycle it checks the first result and that in_ready is high. It then checks that the second, differently classed result appears three edges later, unaffected by the overlap. The whole table is swept through both the unsigned and the float path. Each sweep result is compared bit-exactly with an entry the bench computes in real arithmetic.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_LOOKUP,
        ST_EMIT
    } state_t;

    typedef enum logic [2:0] {
        CL_QNAN,
        CL_SNAN,
        CL_INF,
        CL_ZERO,
        CL_HUGE,
        CL_NORMAL,
        CL_U_LOW,
        CL_U_NORM
    } class_t;

    typedef struct packed {
        class_t     cls;
        logic       sign;
        logic [7:0] expo;
    } decode_t;

    localparam logic [31:0] QUIET_NAN = 32'h7FC0_0000;

    // Table entry for index idx of a table with depth entries:
    // s = floor(4*depth^2/(2q+1) + 1/2), q = depth + idx, stored minus depth.
    function automatic int recip_entry(input int idx, input int depth);
        int q;
        int d;
        int s;
        q = depth + idx;
        d = 2 * q + 1;
        s = (8 * depth * depth + d) / (2 * d);
        return s - depth;
    endfunction

endpackage

// File: rtl/recip_classify.sv
module recip_classify
    import recip_pkg::*;
(
    input  logic        mode_fixed,
    input  logic [31:0] operand,
    output decode_t     dec
);
    logic [7:0]  exp_field;
    logic [22:0] frac_field;

    assign exp_field  = operand[30:23];
    assign frac_field = operand[22:0];

    always_comb begin
        dec.sign = operand[31];
        dec.expo = 8'd253 - exp_field;
        if (mode_fixed) begin
            dec.cls = operand[31] ? CL_U_NORM : CL_U_LOW;
        end else if (exp_field == 8'hFF) begin
            if (frac_field == 23'd0)
                dec.cls = CL_INF;
            else if (frac_field[22])
                dec.cls = CL_QNAN;
            else
                dec.cls = CL_SNAN;
        end else if (exp_field == 8'h00) begin
            dec.cls = CL_ZERO;
        end else if (exp_field >= 8'd253) begin
            dec.cls = CL_HUGE;
        end else begin
            dec.cls = CL_NORMAL;
        end
    end
endmodule

// File: rtl/recip_rom.sv
module recip_rom
    import recip_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] entry
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [IDX_W-1:0] VAL = IDX_W'(recip_entry(g, DEPTH));
        assign table_w[g] = VAL;
    end

    assign entry = table_w[idx];
endmodule

// File: rtl/recip_assemble.sv
module recip_assemble
    import recip_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  decode_t          dec,
    input  logic [IDX_W-1:0] entry,
    output logic [31:0]      result,
    output logic             flag_invalid,
    output logic             flag_divzero,
    output logic             flag_underflow
);
    localparam int MANT_SHIFT = 23 - IDX_W;
    localparam int FIX_SHIFT  = 31 - IDX_W;

    logic [22:0] mant;
    logic [31:0] fixed_res;

    assign mant      = 23'(entry) << MANT_SHIFT;
    assign fixed_res = 32'h8000_0000 | (32'(entry) << FIX_SHIFT);

    always_comb begin
        result         = 32'd0;
        flag_invalid   = 1'b0;
        flag_divzero   = 1'b0;
        flag_underflow = 1'b0;
        unique case (dec.cls)
            CL_QNAN:   result = QUIET_NAN;
            CL_SNAN: begin
                result       = QUIET_NAN;
                flag_invalid = 1'b1;
            end
            CL_INF:    result = {dec.sign, 31'd0};
            CL_ZERO: begin
                result       = {dec.sign, 8'hFF, 23'd0};
                flag_divzero = 1'b1;
            end
            CL_HUGE: begin
                result         = {dec.sign, 31'd0};
                flag_underflow = 1'b1;
            end
            CL_NORMAL: result = {dec.sign, dec.expo, mant};
            CL_U_LOW:  result = 32'hFFFF_FFFF;
            CL_U_NORM: result = fixed_res;
            default:   result = 32'd0;
        endcase
    end
endmodule

// File: rtl/recip_estimator.sv
module recip_estimator
    import recip_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_mode,
    input  logic [31:0] in_operand,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic        out_invalid,
    output logic        out_divzero,
    output logic        out_underflow
);
    state_t           state_q, state_d;
    logic             accept;
    logic [31:0]      op_q;
    logic             mode_q;
    decode_t          dec_w, dec_q;
    logic [IDX_W-1:0] idx_w, idx_q, entry_w;
    logic [31:0]      res_w, res_q;
    logic             inv_w, dz_w, uf_w;
    logic             inv_q, dz_q, uf_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_DECODE : ST_IDLE;
            ST_DECODE: state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_EMIT;
            ST_EMIT:   state_d = in_valid ? ST_DECODE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        in_ready  = (state_q == ST_IDLE) || (state_q == ST_EMIT);
        out_valid = (state_q == ST_EMIT);
    end

    assign accept = in_valid && in_ready;

    recip_classify u_classify (
        .mode_fixed (mode_q),
        .operand    (op_q),
        .dec        (dec_w)
    );

    assign idx_w = mode_q ? op_q[30 -: IDX_W] : op_q[22 -: IDX_W];

    recip_rom #(.IDX_W(IDX_W)) u_rom (
        .idx   (idx_q),
        .entry (entry_w)
    );

    recip_assemble #(.IDX_W(IDX_W)) u_assemble (
        .dec            (dec_q),
        .entry          (entry_w),
        .result         (res_w),
        .flag_invalid   (inv_w),
        .flag_divzero   (dz_w),
        .flag_underflow (uf_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= 32'd0;
            mode_q <= 1'b0;
            dec_q  <= '{cls: CL_U_LOW, sign: 1'b0, expo: 8'd0};
            idx_q  <= '0;
            res_q  <= 32'd0;
            inv_q  <= 1'b0;
            dz_q   <= 1'b0;
            uf_q   <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= in_operand;
                mode_q <= in_mode;
            end
            if (state_q == ST_DECODE) begin
                dec_q <= dec_w;
                idx_q <= idx_w;
            end
            if (state_q == ST_LOOKUP) begin
                res_q <= res_w;
                inv_q <= inv_w;
                dz_q  <= dz_w;
                uf_q  <= uf_w;
            end
        end
    end

    assign out_result    = res_q;
    assign out_invalid   = inv_q;
    assign out_divzero   = dz_q;
    assign out_underflow = uf_q;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready, 3));

    assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == QUIET_NAN));

    assert_divzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_divzero) |-> (out_result[30:0] == 31'h7F80_0000));

    assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow) |-> (out_result[30:0] == 31'd0));

    assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode_q && out_result != QUIET_NAN) |-> (out_result[31] == op_q[31]));

    assert_fixed_noflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q) |-> !(out_invalid || out_divzero || out_underflow));

    assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_invalid, out_divzero, out_underflow}) <= 1));
endmodule

// File: tb/tb_recip_estimator.sv
module tb_recip_estimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [31:0] in_operand = 32'd0;
    logic        in_ready, out_valid, out_invalid, out_divzero, out_underflow;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    recip_estimator dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_mode (in_mode), .in_operand (in_operand),
        .out_valid (out_valid), .out_result (out_result),
        .out_invalid (out_invalid), .out_divzero (out_divzero),
        .out_underflow (out_underflow)
    );

    // {req, mode, operand, expected result, expected {invalid, divzero, underflow}}
    localparam int NV = 26;
    localparam logic [71:0] VECS [NV] = '{
        {4'd7,  1'b0, 32'h3F80_0000, 32'h3F7F_8000, 3'b000}, // R7 1.0
        {4'd7,  1'b0, 32'h4000_0000, 32'h3EFF_8000, 3'b000}, // R7 2.0
        {4'd7,  1'b0, 32'hBF80_0000, 32'hBF7F_8000, 3'b000}, // R7 -1.0
        {4'd7,  1'b0, 32'h3FC0_0000, 32'h3F2A_8000, 3'b000}, // R7 1.5
        {4'd7,  1'b0, 32'h4040_0000, 32'h3EAA_8000, 3'b000}, // R7 3.0
        {4'd7,  1'b0, 32'h7E00_0000, 32'h00FF_8000, 3'b000}, // R7 E=252
        {4'd7,  1'b0, 32'h0080_0000, 32'h7E7F_8000, 3'b000}, // R7 E=1
        {4'd7,  1'b0, 32'h3FFF_8000, 32'h3F00_0000, 3'b000}, // R7 last index
        {4'd6,  1'b0, 32'h7E80_0000, 32'h0000_0000, 3'b001}, // R6 2^126
        {4'd6,  1'b0, 32'hFE80_0000, 32'h8000_0000, 3'b001}, // R6 -2^126
        {4'd6,  1'b0, 32'h7F7F_FFFF, 32'h0000_0000, 3'b001}, // R6 max finite
        {4'd4,  1'b0, 32'h7F80_0000, 32'h0000_0000, 3'b000}, // R4 +inf
        {4'd4,  1'b0, 32'hFF80_0000, 32'h8000_0000, 3'b000}, // R4 -inf
        {4'd5,  1'b0, 32'h0000_0000, 32'h7F80_0000, 3'b010}, // R5 +0
        {4'd5,  1'b0, 32'h8000_0000, 32'hFF80_0000, 3'b010}, // R5 -0
        {4'd5,  1'b0, 32'h0000_0001, 32'h7F80_0000, 3'b010}, // R5 subnormal
        {4'd5,  1'b0, 32'h807F_FFFF, 32'hFF80_0000, 3'b010}, // R5 -subnormal
        {4'd3,  1'b0, 32'h7FC0_0001, 32'h7FC0_0000, 3'b000}, // R3 quiet
        {4'd3,  1'b0, 32'h7F80_0001, 32'h7FC0_0000, 3'b100}, // R3 signalling
        {4'd3,  1'b0, 32'hFFA0_0000, 32'h7FC0_0000, 3'b100}, // R3 -signalling
        {4'd3,  1'b0, 32'hFFFF_FFFF, 32'h7FC0_0000, 3'b000}, // R3 -quiet
        {4'd8,  1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b000}, // R8
        {4'd8,  1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 3'b000}, // R8 zero
        {4'd9,  1'b1, 32'h8000_0000, 32'hFF80_0000, 3'b000}, // R9 0.5
        {4'd9,  1'b1, 32'hC000_0000, 32'hAA80_0000, 3'b000}, // R9 0.75
        {4'd10, 1'b1, 32'h7FC0_0001, 32'hFFFF_FFFF, 3'b000}  // R10 NaN bits, unsigned
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_entry(input int i);
        real q, r;
        int  s;
        q = 256.0 + i;
        r = 1.0 / ((q + 0.5) / 512.0);
        s = $rtoi($floor(256.0 * r + 0.5));
        return 8'(s - 256);
    endfunction

    // Called at a negedge; returns at the negedge after the result cycle.
    task automatic run_one(input logic m, input logic [31:0] op, input logic [31:0] er,
                           input logic [2:0] ef, input string req);
        in_mode = m; in_operand = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready && !out_valid, "R2", "busy cycle 1", {62'd0, in_ready, out_valid}, 64'd0);
        @(negedge clk);
        check(!in_ready && !out_valid, "R2", "busy cycle 2", {62'd0, in_ready, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid && out_result == er && {out_invalid, out_divzero, out_underflow} == ef,
              req, $sformatf("op %h", op),
              {28'd0, out_valid, out_invalid, out_divzero, out_underflow, out_result},
              {28'd0, 1'b1, ef, er});
        @(negedge clk);
        check(!out_valid, "R2", "single valid cycle", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready && out_result == 0 && !out_invalid && !out_divzero && !out_underflow,
              "R1", "in reset", {30'd0, out_valid, in_ready, out_result}, {30'd0, 2'b01, 32'd0});
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready && out_result == 0, "R1", "after release",
              {30'd0, out_valid, in_ready, out_result}, {30'd0, 2'b01, 32'd0});

        // R2 idle holds with no request
        repeat (4) @(negedge clk);
        check(!out_valid && in_ready, "R2", "idle", {62'd0, out_valid, in_ready}, 64'd1);

        for (int v = 0; v < NV; v++) begin
            run_one(VECS[v][67], VECS[v][66:35], VECS[v][34:3], VECS[v][2:0],
                    $sformatf("R%0d", VECS[v][71:68]));
        end

        // Full table through both paths: R9 unsigned, R7 float
        for (int i = 0; i < 256; i++) begin
            logic [7:0] e;
            e = ref_entry(i);
            run_one(1'b1, {1'b1, 8'(i), 23'd0}, {1'b1, e, 23'd0}, 3'b000, "R9");
            run_one(1'b0, {1'b0, 8'd127, 8'(i), 15'h7FFF}, {1'b0, 8'd126, e, 15'd0}, 3'b000, "R7");
        end

        // R2 back-to-back: second request offered in the result cycle
        in_mode = 1'b0; in_operand = 32'h4000_0000; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid && in_ready && out_result == 32'h3EFF_8000, "R2", "first of pair",
              {30'd0, out_valid, in_ready, out_result}, {30'd0, 2'b11, 32'h3EFF_8000});
        in_mode = 1'b0; in_operand = 32'h8000_0000; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check(!out_valid && !in_ready, "R2", "pair busy", {62'd0, out_valid, in_ready}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        check(out_valid && out_result == 32'hFF80_0000 && out_divzero, "R5", "second of pair",
              {31'd0, out_divzero, out_result}, {31'd1, 32'hFF80_0000});
        @(negedge clk);

        // R1 reset during processing
        in_mode = 1'b1; in_operand = 32'hC000_0000; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready && out_result == 0, "R1", "reset mid-flight",
              {30'd0, out_valid, in_ready, out_result}, {30'd0, 2'b01, 32'd0});
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!out_valid, "R1", "no stale result", {63'd0, out_valid}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule